// File: doc/BRIEF.md
# I2C Master SCL Bit-Rate Generator

This block produces the serial clock waveform for an I2C master. A power-of-two prescaler divides the peripheral clock into reference ticks. Two programmable 5-bit counts then set how long the clock is driven low and how long it is released. Each phase also carries a fixed overhead that covers the input synchronizer and the glitch filter, so the programmed counts can be taken straight from a frequency calculation.

The high phase watches the bus. The incoming SCL passes through a two-flop synchronizer and a filter that only accepts a level after two consecutive samples agree. Once the overhead part of the high phase has elapsed, the high counter holds for as long as the filtered line still reads low. A slave that stretches the clock, or a bus line that rises slowly, therefore lengthens the high phase instead of shortening it.

Each time the generator ends a phase on its own, it emits a one-cycle tick. The surrounding shifter logic uses this tick to place data and sample bits. Dropping the enable releases the line on the next clock. The next enable always starts with a low phase.

Top module: `scl_bitrate_gen`

## Requirements
- R1: While reset is asserted, and on the clock after enable is sampled low, scl_drive_low and phase_tick are both 0.
- R2: After enable is sampled high, the next clock starts a low phase. The low phase lasts (max(brl,1)+V)·2^cks clock cycles, where V is 4 when cks is 0 and 3 otherwise.
- R3: When the bus line follows the release without delay, the high phase lasts (max(brh,1)+V)·2^cks clock cycles.
- R4: A programmed brl or brh of 0 gives the same phase length as a value of 1.
- R5: When the line is held low after release, the high counter freezes once it has counted V reference ticks. It advances only on ticks where the filtered SCL reads high. The filtered level follows a line rise after 4 clock cycles.
- R6: A pulse on the SCL input that lasts a single clock cycle does not change the filtered level. It therefore does not end a stretch.
- R7: phase_tick is 1 for exactly the first cycle of each phase that follows a completed phase. It is never 1 in the first low phase after enable.
- R8: Dropping enable in the middle of a run releases the line on the next clock without a tick. A later enable starts again from a full low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run the clock generator |
| cks | input | 3 | Prescale select, divide by 2^cks |
| brh | input | 5 | High-phase count |
| brl | input | 5 | Low-phase count |
| scl_in | input | 1 | Raw SCL level seen on the bus |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| phase_tick | output | 1 | One-cycle pulse at each phase change |

## Verification
The critical coincidence is in the high phase. The counter reaches the overhead count on the same reference tick that the filtered SCL rise becomes visible. One cycle of difference in the slave's release decides whether the phase gains a tick. The bench models a stretching slave that releases the line a chosen number of cycles after the master. It sweeps that release delay across the boundary: one cycle gives no extra time and two cycles give one extra cycle at prescale 0. It also covers larger prescales, where the extra time is rounded up to whole reference ticks. Each measured high length is compared with a figure the bench computes from the release delay, the filter latency and the tick period. A single-cycle glitch is placed inside one stretch, and the bench confirms the stretch length does not change.

// File: rtl/scl_brg_pkg.sv
package scl_brg_pkg;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } scl_phase_e;

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int unsigned CKS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CKS_W-1:0] cks,
  output logic             ref_tick
);

  localparam int unsigned PS_W = (1 << CKS_W) - 1;

  logic [PS_W-1:0] pcnt_q, pcnt_n;
  logic [PS_W:0]   span_w;
  logic [PS_W-1:0] mask_w;

  // terminal count is 2^cks - 1
  always_comb begin
    span_w = ((PS_W+1)'(1) << cks) - (PS_W+1)'(1);
    mask_w = span_w[PS_W-1:0];
  end

  assign ref_tick = run && (pcnt_q == mask_w);

  always_comb begin
    pcnt_n = pcnt_q;
    if (!run) begin
      pcnt_n = '0;
    end else if (ref_tick) begin
      pcnt_n = '0;
    end else begin
      pcnt_n = pcnt_q + PS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_n;
    end
  end

endmodule

// File: rtl/scl_input_filter.sv
module scl_input_filter #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  output logic scl_clean
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   agree_q;
  logic                   clean_q, clean_n;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b1;
        else        sync_q[0] <= scl_raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b1;
        else        sync_q[i] <= sync_q[i-1];
      end
    end
  end

  // level accepted only when two successive synchronized samples match
  always_comb begin
    clean_n = clean_q;
    if (sync_q[SYNC_STAGES-1] == agree_q) begin
      clean_n = agree_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      agree_q <= 1'b1;
      clean_q <= 1'b1;
    end else begin
      agree_q <= sync_q[SYNC_STAGES-1];
      clean_q <= clean_n;
    end
  end

  assign scl_clean = clean_q;

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
  import scl_brg_pkg::*;
#(
  parameter int unsigned CKS_W     = 3,
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned OVH_UNDIV = 4,
  parameter int unsigned OVH_DIV   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ref_tick,
  input  logic             scl_high,
  input  logic [CKS_W-1:0] cks,
  input  logic [CNT_W-1:0] brh,
  input  logic [CNT_W-1:0] brl,
  output logic             run,
  output logic             drive_low,
  output logic             phase_tick
);

  localparam int unsigned PC_W = CNT_W + 1;

  scl_phase_e      phase_q, phase_n;
  logic            run_q, run_n;
  logic            ptick_q, ptick_n;
  logic [PC_W-1:0] cnt_q, cnt_n;

  logic [PC_W-1:0] brh_c, brl_c, ovh_v, target_v;
  logic            may_count;

  always_comb begin
    brh_c    = (brh == '0) ? PC_W'(1) : {1'b0, brh};
    brl_c    = (brl == '0) ? PC_W'(1) : {1'b0, brl};
    ovh_v    = (cks == '0) ? PC_W'(OVH_UNDIV) : PC_W'(OVH_DIV);
    target_v = ((phase_q == PH_LOW) ? brl_c : brh_c) + ovh_v;
    // the high count waits for the line once the overhead slots are spent
    may_count = (phase_q == PH_LOW) || (cnt_q < ovh_v) || scl_high;
  end

  always_comb begin
    phase_n = phase_q;
    run_n   = run_q;
    cnt_n   = cnt_q;
    ptick_n = 1'b0;
    if (!en) begin
      run_n   = 1'b0;
      phase_n = PH_HIGH;
      cnt_n   = '0;
    end else if (!run_q) begin
      run_n   = 1'b1;
      phase_n = PH_LOW;
      cnt_n   = '0;
    end else if (ref_tick && may_count) begin
      if (cnt_q == target_v - PC_W'(1)) begin
        phase_n = (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
        cnt_n   = '0;
        ptick_n = 1'b1;
      end else begin
        cnt_n = cnt_q + PC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HIGH;
      run_q   <= 1'b0;
      cnt_q   <= '0;
      ptick_q <= 1'b0;
    end else begin
      phase_q <= phase_n;
      run_q   <= run_n;
      cnt_q   <= cnt_n;
      ptick_q <= ptick_n;
    end
  end

  assign run        = run_q;
  assign drive_low  = run_q && (phase_q == PH_LOW);
  assign phase_tick = ptick_q;

endmodule

// File: rtl/scl_bitrate_gen.sv
module scl_bitrate_gen #(
  parameter int unsigned CKS_W       = 3,
  parameter int unsigned CNT_W       = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned OVH_UNDIV   = 4,
  parameter int unsigned OVH_DIV     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CKS_W-1:0] cks,
  input  logic [CNT_W-1:0] brh,
  input  logic [CNT_W-1:0] brl,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             phase_tick
);

  logic [1:0] rst_pipe_q;
  logic       rst_n_int;
  logic       run_w, tick_w, scl_clean_w;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  scl_prescaler #(.CKS_W(CKS_W)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .run      (run_w),
    .cks      (cks),
    .ref_tick (tick_w)
  );

  scl_input_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .scl_raw   (scl_in),
    .scl_clean (scl_clean_w)
  );

  scl_phase_timer #(
    .CKS_W     (CKS_W),
    .CNT_W     (CNT_W),
    .OVH_UNDIV (OVH_UNDIV),
    .OVH_DIV   (OVH_DIV)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .en         (en),
    .ref_tick   (tick_w),
    .scl_high   (scl_clean_w),
    .cks        (cks),
    .brh        (brh),
    .brl        (brl),
    .run        (run_w),
    .drive_low  (scl_drive_low),
    .phase_tick (phase_tick)
  );

endmodule

// File: rtl/scl_bitrate_gen_chk.sv
module scl_bitrate_gen_chk #(
  parameter int unsigned CKS_W     = 3,
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned OVH_UNDIV = 4,
  parameter int unsigned OVH_DIV   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [CKS_W-1:0] cks,
  input logic [CNT_W-1:0] brh,
  input logic [CNT_W-1:0] brl,
  input logic             scl_drive_low,
  input logic             phase_tick
);

  logic [15:0] low_len_q, high_len_q;
  logic [15:0] low_exp, high_exp;
  logic [15:0] ovh16;

  always_comb begin
    ovh16    = (cks == '0) ? 16'(OVH_UNDIV) : 16'(OVH_DIV);
    low_exp  = (((brl == '0) ? 16'd1 : 16'(brl)) + ovh16) << cks;
    high_exp = (((brh == '0) ? 16'd1 : 16'(brh)) + ovh16) << cks;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_len_q  <= '0;
      high_len_q <= '0;
    end else begin
      low_len_q  <= scl_drive_low ? low_len_q + 16'd1 : 16'd0;
      high_len_q <= scl_drive_low ? 16'd0 : high_len_q + 16'd1;
    end
  end

  // R1
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_drive_low && !phase_tick));

  // R7
  tick_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_tick |-> (scl_drive_low != $past(scl_drive_low)));

  // R2
  low_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_tick && !scl_drive_low) |-> (low_len_q == low_exp));

  // R3
  high_min_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_tick && scl_drive_low) |-> (high_len_q >= high_exp));

endmodule

bind scl_bitrate_gen scl_bitrate_gen_chk #(
  .CKS_W     (CKS_W),
  .CNT_W     (CNT_W),
  .OVH_UNDIV (OVH_UNDIV),
  .OVH_DIV   (OVH_DIV)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .en            (en),
  .cks           (cks),
  .brh           (brh),
  .brl           (brl),
  .scl_drive_low (scl_drive_low),
  .phase_tick    (phase_tick)
);

// File: tb/scl_bitrate_gen_tb_top.sv
module scl_bitrate_gen_tb_top;

  logic       clk;
  logic       rst_n;
  logic       en;
  logic [2:0] cks;
  logic [4:0] brh;
  logic [4:0] brl;
  logic       scl_line;
  logic       scl_drive_low;
  logic       phase_tick;

  int  checks   = 0;
  int  failures = 0;
  bit  done     = 0;

  int  stretch_k = 0;
  bit  glitch_en = 0;
  int  rel_cnt   = 0;
  bit  hold      = 0;
  bit  glitch    = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  scl_bitrate_gen dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .cks           (cks),
    .brh           (brh),
    .brl           (brl),
    .scl_in        (scl_line),
    .scl_drive_low (scl_drive_low),
    .phase_tick    (phase_tick)
  );

  // slave model: holds the line low for stretch_k cycles after the release
  always @(negedge clk) begin
    if (scl_drive_low) rel_cnt = 0;
    else if (rel_cnt < 100000) rel_cnt = rel_cnt + 1;
    hold   = (rel_cnt < stretch_k);
    glitch = glitch_en && (rel_cnt == 3);
  end

  assign scl_line = !scl_drive_low && (!hold || glitch);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one low phase, one high phase, then a mid-run disable
  task automatic run_cfg(input int c, input int lo, input int hi, input int k_rel,
                         input bit glt, input string hi_tag);
    int p, ovh, loc, hic, k, t0, num, s, exp_lo, exp_hi, lcnt, hcnt;
    p   = 1 << c;
    ovh = (c == 0) ? 4 : 3;
    loc = (lo == 0) ? 1 : lo;
    hic = (hi == 0) ? 1 : hi;
    k   = (k_rel < 1) ? 1 : k_rel;
    t0  = (ovh + 1) * p;
    num = k + 4 - t0;
    s   = (num > 0) ? (num + p - 1) / p : 0;
    exp_lo = (loc + ovh) * p;
    exp_hi = (hic + ovh + s) * p;

    @(negedge clk);
    cks = c[2:0]; brl = lo[4:0]; brh = hi[4:0];
    stretch_k = k_rel; glitch_en = glt;
    en = 1'b1;
    @(negedge clk);
    // R7: no tick on the first low phase after enable
    check(scl_drive_low && !phase_tick, "R7", {phase_tick, scl_drive_low}, 1);
    lcnt = 0;
    while (scl_drive_low) begin lcnt++; @(negedge clk); end
    // R2 / R4 low phase length
    check(lcnt == exp_lo, (lo == 0) ? "R4" : "R2", lcnt, exp_lo);
    check(phase_tick == 1'b1, "R7", phase_tick, 1);
    hcnt = 0;
    while (!scl_drive_low) begin hcnt++; @(negedge clk); end
    // R3 / R4 / R5 / R6 high phase length
    check(hcnt == exp_hi, (hi == 0) ? "R4" : hi_tag, hcnt, exp_hi);
    check(phase_tick == 1'b1, "R7", phase_tick, 1);
    en = 1'b0;
    @(negedge clk);
    // R8: release on the next clock, no tick
    check(!scl_drive_low && !phase_tick, "R8", {phase_tick, scl_drive_low}, 0);
    repeat (6) @(negedge clk);
    // R1: stays idle while disabled
    check(!scl_drive_low && !phase_tick, "R1", {phase_tick, scl_drive_low}, 0);
    stretch_k = 0; glitch_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; cks = '0; brh = 5'd1; brl = 5'd1;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!scl_drive_low && !phase_tick, "R1", {phase_tick, scl_drive_low}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!scl_drive_low && !phase_tick, "R1", {phase_tick, scl_drive_low}, 0);

    for (int c = 0; c < 8; c++) begin
      if (c <= 3) begin
        run_cfg(c, 1, 1, 0, 0, "R3");
        run_cfg(c, 31, 2, 0, 0, "R3");
        run_cfg(c, 6, 31, 0, 0, "R3");
      end else begin
        run_cfg(c, 3, 2, 0, 0, "R3");
      end
    end

    // R4: zero counts behave as one
    run_cfg(0, 0, 0, 0, 0, "R3");
    run_cfg(2, 0, 5, 0, 0, "R3");
    run_cfg(1, 7, 0, 0, 0, "R3");

    // R5: stretch boundary and larger delays
    run_cfg(0, 2, 3, 1, 0, "R5");
    run_cfg(0, 2, 3, 2, 0, "R5");
    run_cfg(0, 2, 3, 9, 0, "R5");
    run_cfg(1, 4, 2, 12, 0, "R5");
    run_cfg(3, 1, 1, 30, 0, "R5");

    // R6: one-cycle glitch inside a stretch is ignored
    run_cfg(0, 2, 3, 10, 1, "R6");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule